// File: doc/BRIEF.md
# Lockable Timer Control Register Bank

This block is the register bank in front of a motor-control PWM timer. It holds one 8-bit control word and a two-flag status register, plus a parameterised set of compare buffer registers: by default three phase buffers and one period buffer. The control word starts and stops the timer's period counter and dead-time counter through a single run-enable output. It also gates two compare-match flags onto two interrupt request lines.

The control word carries a one-way lock bit. Once software sets it, the bank stops returning data for everything except the status register. It also refuses writes to everything except the status register and the buffer registers, and that includes the control word itself. Only a hardware reset removes the lock. A blocked access has no side effect: a blocked read returns zero and a blocked write is dropped.

Status flags are set by single-cycle pulses from the compare logic. Software clears a flag by reading it as 1 and then writing 0 to it. A set pulse in the same cycle as a clear wins. The bus port is synchronous: read data appears in the cycle after the read strobe, and it is zero in every other cycle.

Top module: `tmr_ctl_bank`

## Requirements
- R1: After reset, the control word, both status flags and every buffer register read as 0, and run_en, irq_n and irq_m are 0.
- R2: The control word is at address 0. Bit 6 is run, bit 5 is lock, bit 1 is interrupt enable N and bit 0 is interrupt enable M. Bits 7 and 4 to 2 always read 0, whatever value was written to them.
- R3: run_en equals the run bit (bit 6) of the control word.
- R4: The status register is at address 1, with flag N in bit 1 and flag M in bit 0. irq_n is 1 exactly when flag N and enable N are both 1. irq_m follows the same rule with flag M and enable M.
- R5: A flag_set pulse sets its flag. Writing 0 to a flag bit clears it only if that flag was read as 1 by an earlier status read. Writing 1 to a flag bit, or writing 0 to it without such a read, leaves the flag unchanged.
- R6: When a set pulse and a clear for the same flag fall in the same cycle, the flag ends up 1.
- R7: A control write with bit 5 set updates the other fields of that same write. From then on, every control write is ignored.
- R8: While locked, reads of the control word and of the buffer registers return 0, and the status register still reads its true value.
- R9: While locked, the read-then-write-0 sequence on the status register still clears flags.
- R10: Buffer registers occupy addresses 4 to 7 and read back the last value written. Read data appears in the cycle after rd_en and is 0 in any cycle after rd_en was low. Reads of unmapped addresses return 0.
- R11: A hardware reset removes the lock, and control writes and reads work again afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW (4) | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | DW (8) | Write data |
| rdata | output | DW (8) | Read data, one cycle after rd_en |
| flag_set_n | input | 1 | Compare-match pulse that sets flag N |
| flag_set_m | input | 1 | Compare-match pulse that sets flag M |
| run_en | output | 1 | Counter run enable for the period and dead-time counters |
| irq_n | output | 1 | Interrupt request N |
| irq_m | output | 1 | Interrupt request M |

## Verification
The bench builds the block with its defaults: a 4-bit address, 8-bit data, three phase buffers and one period buffer. This places every mapped register, and unmapped addresses on both sides of the buffer window, within reach of a small random address range. Random traffic runs twice, once before the lock and once after it, so that every register is exercised in both access regimes. Reset is applied in the middle of the run to show that the lock can be removed.

// File: rtl/tmr_ctl_pkg.sv
package tmr_ctl_pkg;
   localparam int CTL_W     = 8;
   localparam int BIT_RUN   = 6;
   localparam int BIT_LOCK  = 5;
   localparam int BIT_IEN_N = 1;
   localparam int BIT_IEN_M = 0;
   localparam int FLG_N     = 1;
   localparam int FLG_M     = 0;
   localparam int NUM_FLAG  = 2;

   typedef struct packed {
      logic run;
      logic lock;
      logic ien_n;
      logic ien_m;
   } ctl_t;
endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode #(
   parameter int AW        = 4,
   parameter int ADDR_CTL  = 0,
   parameter int ADDR_STAT = 1,
   parameter int BUF_BASE  = 4,
   parameter int NUM_BUF   = 4
) (
   input  logic [AW-1:0]      addr,
   output logic               hit_ctl,
   output logic               hit_stat,
   output logic [NUM_BUF-1:0] hit_buf
);
   localparam logic [AW-1:0] A_CTL  = AW'(ADDR_CTL);
   localparam logic [AW-1:0] A_STAT = AW'(ADDR_STAT);

   assign hit_ctl  = (addr == A_CTL);
   assign hit_stat = (addr == A_STAT);

   for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf_dec
      localparam logic [AW-1:0] A_BUF = AW'(BUF_BASE + i);
      assign hit_buf[i] = (addr == A_BUF);
   end
endmodule

// File: rtl/tmr_ctl_reg.sv
module tmr_ctl_reg
   import tmr_ctl_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_req,
   input  logic [DW-1:0] wdata,
   output ctl_t          ctl,
   output logic [DW-1:0] rd_img
);
   ctl_t ctl_q;
   logic wr_ok;

   // once locked, the word itself refuses further writes
   assign wr_ok = wr_req & ~ctl_q.lock;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (wr_ok) begin
         ctl_q.run   <= wdata[BIT_RUN];
         ctl_q.lock  <= wdata[BIT_LOCK];
         ctl_q.ien_n <= wdata[BIT_IEN_N];
         ctl_q.ien_m <= wdata[BIT_IEN_M];
      end
   end

   assign ctl = ctl_q;

   always_comb begin
      rd_img            = '0;
      rd_img[BIT_RUN]   = ctl_q.run;
      rd_img[BIT_LOCK]  = ctl_q.lock;
      rd_img[BIT_IEN_N] = ctl_q.ien_n;
      rd_img[BIT_IEN_M] = ctl_q.ien_m;
   end
endmodule

// File: rtl/tmr_ctl_status.sv
module tmr_ctl_status #(
   parameter int NF = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_hit,
   input  logic          wr_hit,
   input  logic [NF-1:0] wbits,
   input  logic [NF-1:0] set_p,
   output logic [NF-1:0] flag_o
);
   for (genvar i = 0; i < NF; i++) begin : g_flag
      logic f_q;
      logic armed_q;
      logic clr;

      // clear needs a prior read that saw the flag at 1
      assign clr = wr_hit & ~wbits[i] & armed_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            f_q     <= 1'b0;
            armed_q <= 1'b0;
         end else begin
            f_q <= set_p[i] | (f_q & ~clr);
            if (clr)
               armed_q <= 1'b0;
            else if (rd_hit && f_q)
               armed_q <= 1'b1;
         end
      end

      assign flag_o[i] = f_q;
   end
endmodule

// File: rtl/tmr_ctl_bufbank.sv
module tmr_ctl_bufbank #(
   parameter int DW      = 8,
   parameter int NUM_BUF = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_BUF-1:0] wsel,
   input  logic [NUM_BUF-1:0] rsel,
   input  logic [DW-1:0]      wdata,
   output logic [DW-1:0]      rd_val
);
   logic [DW-1:0] buf_q [NUM_BUF];

   for (genvar i = 0; i < NUM_BUF; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            buf_q[i] <= '0;
         else if (wsel[i])
            buf_q[i] <= wdata;
      end
   end

   always_comb begin
      rd_val = '0;
      for (int k = 0; k < NUM_BUF; k++)
         rd_val = rd_val | (rsel[k] ? buf_q[k] : '0);
   end
endmodule

// File: rtl/tmr_ctl_bank.sv
module tmr_ctl_bank
   import tmr_ctl_pkg::*;
#(
   parameter int AW         = 4,
   parameter int DW         = 8,
   parameter int NUM_PHASE  = 3,
   parameter int NUM_PERIOD = 1,
   parameter int ADDR_CTL   = 0,
   parameter int ADDR_STAT  = 1,
   parameter int BUF_BASE   = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic          flag_set_n,
   input  logic          flag_set_m,
   output logic          run_en,
   output logic          irq_n,
   output logic          irq_m
);
   localparam int NUM_BUF = NUM_PHASE + NUM_PERIOD;
   localparam int BUF_END = BUF_BASE + NUM_BUF;

   if (DW < CTL_W) begin : g_chk_dw
      $error("tmr_ctl_bank: DW must hold the 8-bit control word");
   end
   if (NUM_BUF < 1) begin : g_chk_nbuf
      $error("tmr_ctl_bank: at least one buffer register is required");
   end
   if (BUF_END > (1 << AW)) begin : g_chk_aw
      $error("tmr_ctl_bank: buffer window exceeds address space");
   end
   if (ADDR_CTL == ADDR_STAT) begin : g_chk_ovl
      $error("tmr_ctl_bank: control and status addresses collide");
   end
   if ((ADDR_CTL >= BUF_BASE && ADDR_CTL < BUF_END) ||
       (ADDR_STAT >= BUF_BASE && ADDR_STAT < BUF_END)) begin : g_chk_win
      $error("tmr_ctl_bank: buffer window overlaps a control address");
   end

   logic               hit_ctl;
   logic               hit_stat;
   logic [NUM_BUF-1:0] hit_buf;
   ctl_t               ctl;
   logic [DW-1:0]      ctl_img;
   logic               lock;
   logic [1:0]         flag_q;
   logic [DW-1:0]      buf_val;
   logic [DW-1:0]      stat_img;
   logic [DW-1:0]      rd_mux;
   logic [DW-1:0]      rdata_q;

   tmr_ctl_decode #(
      .AW(AW), .ADDR_CTL(ADDR_CTL), .ADDR_STAT(ADDR_STAT),
      .BUF_BASE(BUF_BASE), .NUM_BUF(NUM_BUF)
   ) u_dec (
      .addr    (addr),
      .hit_ctl (hit_ctl),
      .hit_stat(hit_stat),
      .hit_buf (hit_buf)
   );

   tmr_ctl_reg #(.DW(DW)) u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_req(wr_en & hit_ctl),
      .wdata (wdata),
      .ctl   (ctl),
      .rd_img(ctl_img)
   );

   assign lock = ctl.lock;

   tmr_ctl_status #(.NF(NUM_FLAG)) u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_hit(rd_en & hit_stat),
      .wr_hit(wr_en & hit_stat),
      .wbits ({wdata[FLG_N], wdata[FLG_M]}),
      .set_p ({flag_set_n, flag_set_m}),
      .flag_o(flag_q)
   );

   // buffers take writes regardless of the lock
   tmr_ctl_bufbank #(.DW(DW), .NUM_BUF(NUM_BUF)) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .wsel  (wr_en ? hit_buf : '0),
      .rsel  (hit_buf),
      .wdata (wdata),
      .rd_val(buf_val)
   );

   always_comb begin
      stat_img        = '0;
      stat_img[FLG_N] = flag_q[1];
      stat_img[FLG_M] = flag_q[0];
   end

   always_comb begin
      if (hit_stat)
         rd_mux = stat_img;
      else if (lock)
         rd_mux = '0;
      else if (hit_ctl)
         rd_mux = ctl_img;
      else if (|hit_buf)
         rd_mux = buf_val;
      else
         rd_mux = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else
         rdata_q <= rd_en ? rd_mux : '0;
   end

   assign rdata  = rdata_q;
   assign run_en = ctl.run;
   assign irq_n  = flag_q[1] & ctl.ien_n;
   assign irq_m  = flag_q[0] & ctl.ien_m;
endmodule

// File: rtl/tmr_ctl_bank_chk.sv
module tmr_ctl_bank_chk #(
   parameter int AW        = 4,
   parameter int DW        = 8,
   parameter int ADDR_STAT = 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] addr,
   input logic          rd_en,
   input logic [DW-1:0] rdata,
   input logic          flag_set_n,
   input logic          flag_set_m,
   input logic          run_en,
   input logic          irq_n,
   input logic          irq_m,
   input logic          lock_q,
   input logic [1:0]    flags
);
   localparam logic [AW-1:0] A_STAT = AW'(ADDR_STAT);

   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q); // R7
   AST_RUN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> $stable(run_en)); // R7
   AST_SET_BEATS_CLR_N: assert property (@(posedge clk) disable iff (!rst_n)
      flag_set_n |=> flags[1]); // R6
   AST_SET_BEATS_CLR_M: assert property (@(posedge clk) disable iff (!rst_n)
      flag_set_m |=> flags[0]); // R6
   AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rdata == '0)); // R10
   AST_LOCKED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && rd_en && addr != A_STAT) |=> (rdata == '0)); // R8
   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_n |-> flags[1]) and (irq_m |-> flags[0])); // R4
endmodule

bind tmr_ctl_bank tmr_ctl_bank_chk #(
   .AW(AW), .DW(DW), .ADDR_STAT(ADDR_STAT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .addr      (addr),
   .rd_en     (rd_en),
   .rdata     (rdata),
   .flag_set_n(flag_set_n),
   .flag_set_m(flag_set_m),
   .run_en    (run_en),
   .irq_n     (irq_n),
   .irq_m     (irq_m),
   .lock_q    (lock),
   .flags     (flag_q)
);

// File: tb/tmr_ctl_bank_bench.sv
module tmr_ctl_bank_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam int NBUF = 4;
   localparam int BBASE = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          flag_set_n = 1'b0;
   logic          flag_set_m = 1'b0;
   logic          run_en, irq_n, irq_m;

   logic [7:0] m_ctl;
   logic       m_lock;
   logic [1:0] m_flag, m_arm;
   logic [7:0] m_buf [NBUF];
   int n_tests = 0;
   int n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr_ctl_bank u_tmr_ctl_bank (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .flag_set_n(flag_set_n),
      .flag_set_m(flag_set_m), .run_en(run_en), .irq_n(irq_n), .irq_m(irq_m)
   );

   task automatic chk(input string req, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_read(input int a);
      if (a == 1) return {6'b0, m_flag};
      if (m_lock) return 8'h00;
      if (a == 0) return m_ctl;
      if (a >= BBASE && a < BBASE + NBUF) return m_buf[a - BBASE];
      return 8'h00;
   endfunction

   task automatic model_reset();
      m_ctl = 8'h00; m_lock = 1'b0; m_flag = 2'b00; m_arm = 2'b00;
      for (int i = 0; i < NBUF; i++) m_buf[i] = 8'h00;
   endtask

   task automatic outs(input string req);
      chk(req, "run_en R3", {7'b0, run_en}, {7'b0, m_ctl[6]});
      chk(req, "irq_n R4", {7'b0, irq_n}, {7'b0, m_flag[1] & m_ctl[1]});
      chk(req, "irq_m R4", {7'b0, irq_m}, {7'b0, m_flag[0] & m_ctl[0]});
   endtask

   task automatic cyc(input int a, input logic we, input logic re,
                      input logic [7:0] wd, input logic [1:0] fs, input string req);
      logic [7:0] exp_rd;
      logic [1:0] clr;
      addr = AW'(a); wr_en = we; rd_en = re; wdata = wd;
      flag_set_n = fs[1]; flag_set_m = fs[0];
      exp_rd = re ? exp_read(a) : 8'h00;
      for (int b = 0; b < 2; b++) begin
         clr[b] = we && a == 1 && !wd[b] && m_arm[b];
         if (clr[b]) m_arm[b] = 1'b0;
         else if (re && a == 1 && m_flag[b]) m_arm[b] = 1'b1;
         m_flag[b] = fs[b] | (m_flag[b] & ~clr[b]);
      end
      if (we && a == 0 && !m_lock) begin
         m_ctl = wd & 8'h63;
         m_lock = wd[5];
      end
      if (we && a >= BBASE && a < BBASE + NBUF) m_buf[a - BBASE] = wd;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; flag_set_n = 1'b0; flag_set_m = 1'b0;
      chk(req, "rdata", rdata, exp_rd);
      outs(req);
   endtask

   task automatic rd(input int a, input string req);
      cyc(a, 1'b0, 1'b1, 8'h00, 2'b00, req);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; model_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog act=running exp=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      model_reset();
      do_reset();
      // R1 reset state
      outs("R1");
      for (int a = 0; a < 8; a++) rd(a, "R1");

      // R2 layout, reserved bits read 0; R3 run
      cyc(0, 1'b1, 1'b0, 8'hDF, 2'b00, "R2");
      rd(0, "R2");
      chk("R2", "ctl image", rdata, 8'h43);
      chk("R3", "run_en high", {7'b0, run_en}, 8'h01);

      // R4 interrupt gating
      cyc(2, 1'b0, 1'b0, 8'h00, 2'b10, "R4");
      chk("R4", "irq_n asserted", {7'b0, irq_n}, 8'h01);
      cyc(0, 1'b1, 1'b0, 8'h40, 2'b00, "R4");
      chk("R4", "irq_n gated off", {7'b0, irq_n}, 8'h00);
      cyc(0, 1'b1, 1'b0, 8'h43, 2'b01, "R4");

      // R5 clear protocol
      cyc(1, 1'b1, 1'b0, 8'h00, 2'b00, "R5");
      rd(1, "R5");
      chk("R5", "no clear without read", rdata, 8'h03);
      cyc(1, 1'b1, 1'b0, 8'hFF, 2'b00, "R5");
      cyc(1, 1'b1, 1'b0, 8'h01, 2'b00, "R5");
      rd(1, "R5");
      chk("R5", "N cleared only", rdata, 8'h01);

      // R6 set wins over clear
      rd(1, "R6");
      cyc(1, 1'b1, 1'b0, 8'h00, 2'b01, "R6");
      rd(1, "R6");
      chk("R6", "M survives", rdata, 8'h01);

      // R10 buffers, unmapped, idle read
      for (int i = 0; i < NBUF; i++) cyc(BBASE + i, 1'b1, 1'b0, 8'(8'hA0 + i), 2'b00, "R10");
      for (int a = 2; a < 16; a++) rd(a, "R10");
      cyc(5, 1'b0, 1'b0, 8'h00, 2'b00, "R10");

      // random, unlocked
      for (int n = 0; n < 400; n++) begin
         int a = int'($urandom_range(0, 9));
         logic [7:0] wd = 8'($urandom);
         if (a == 0) wd[5] = 1'b0;
         cyc(a, 1'($urandom), 1'($urandom),
             wd, {($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0)}, "R10");
      end

      // R7 lock in the same write as other fields
      cyc(0, 1'b1, 1'b0, 8'h62, 2'b00, "R7");
      chk("R7", "run set with lock", {7'b0, run_en}, 8'h01);
      cyc(0, 1'b1, 1'b0, 8'h00, 2'b00, "R7");
      chk("R7", "run held after blocked write", {7'b0, run_en}, 8'h01);

      // R8 reads blocked except status
      rd(0, "R8");
      chk("R8", "ctl hidden", rdata, 8'h00);
      rd(BBASE, "R8");
      chk("R8", "buffer hidden", rdata, 8'h00);
      cyc(2, 1'b0, 1'b0, 8'h00, 2'b11, "R8");
      rd(1, "R8");
      chk("R8", "status visible", rdata, 8'h03);

      // R9 clear under lock
      cyc(1, 1'b1, 1'b0, 8'h01, 2'b00, "R9");
      rd(1, "R9");
      chk("R9", "N cleared while locked", rdata, 8'h01);

      // random, locked
      for (int n = 0; n < 400; n++) begin
         cyc(int'($urandom_range(0, 9)), 1'($urandom), 1'($urandom), 8'($urandom),
             {($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0)}, "R8");
      end

      // R11 reset unlocks
      do_reset();
      outs("R11");
      cyc(0, 1'b1, 1'b0, 8'h41, 2'b00, "R11");
      rd(0, "R11");
      chk("R11", "ctl writable again", rdata, 8'h41);
      cyc(BBASE + 3, 1'b1, 1'b0, 8'h5A, 2'b00, "R11");
      rd(BBASE + 3, "R11");
      chk("R11", "buffer readable again", rdata, 8'h5A);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule